// File: doc/BRIEF.md
# Character BIST Generator and Checker

This block is the self-test pair for a 10-bit character link. Its transmit half either passes the host's parallel characters through, or, while its active-low enable is held low, replaces them with a repeating pseudo-random sequence of 511 characters. Once per completed sequence it raises its error output for a single character period, so the host can watch progress. Its receive half compares incoming characters against a locally regenerated copy of the same sequence. It locks onto the stream by seeding its generator from the received characters, and it reports the outcome on the two low data bits plus a dedicated status pin.

Each character carries a 9-bit generator state in bits [8:0] and the XOR of those nine bits in bit 9. The generator is a 9-bit maximal-length shift register for x^9 + x^5 + 1. It shifts left by one place per character, and the new low bit is state[8] XOR state[4]. The two directions have separate enables, share one character clock and can run together or apart. The serializer, the line code, clock recovery and the analog path sit outside this block.

Top module: `char_bist_link`

## Requirements
- R1: With `txBistEnN` = 1, `txDataOut` equals `txDataIn` in the same cycle and `txErr` stays 0.
- R2: With `txBistEnN` = 0, `txDataOut` = {^s, s}. Here s is the 9-bit state, which is 9'h001 on the first enabled cycle and steps to {s[7:0], s[8]^s[4]} on every enabled cycle. The sequence repeats every 511 characters, and it restarts from 9'h001 after any disabled cycle.
- R3: While transmit BIST runs, `txErr` is 1 for exactly one cycle per pass. This is the cycle that carries state 9'h100, the 511th character counted from enable (index 510 mod 511).
- R4: When `rxBistCtl` is not 2'b10, `rxDataOut` repeats `rxDataIn` one cycle later and `rxStatus` is 0. The checker returns to the waiting state.
- R5: When `rxBistCtl` = 2'b10, the output for each received character appears one cycle later. `rxDataOut[9:2]` = 0 and `rxDataOut[1:0]` carries a code: 00 = waiting for sync, 01 = match, 10 = mismatch.
- R6: While waiting, every character reports 00, including the one that completes sync. A character matches if it equals {^n, n}, where n is the step of bits [8:0] of the character received one cycle earlier. Three consecutive matches declare sync.
- R7: In sync, the expectation advances on its own by one step per character, without reloading. Each character reports 01 if it equals the expectation and 10 otherwise.
- R8: The fourth mismatch within one pass returns the checker to waiting. Pass boundaries follow the expected character with state 9'h100, and the mismatch count clears after that character.
- R9: In sync, `rxStatus` is 1 exactly for the character whose expected state is 9'h100, and 0 otherwise.
- R10: While `rstN` is low, `rxDataOut` = 0, `rxStatus` = 0 and the checker is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txBistEnN | input | 1 | Transmit BIST enable, active low |
| txDataIn | input | 10 | Host transmit character |
| txDataOut | output | 10 | Character toward the serializer |
| txErr | output | 1 | Transmit error line; one-cycle pass pulse in BIST |
| rxBistCtl | input | 2 | Receive BIST control; 2'b10 selects the checker |
| rxDataIn | input | 10 | Character from the deserializer |
| rxDataOut | output | 10 | Received character, or status code in bits [1:0] |
| rxStatus | output | 1 | Pass-end marker while in sync |

## Verification
The bench loops the generator into the checker and flips a bit at chosen positions, with the error pattern placed to hit the pass limit. Three errors land in one pass; three sit either side of a boundary; four fall in a single pass. A checker that never clears its count at the boundary would drop sync on the straddling burst, and one that counted loosely would stay synced through four errors. The bench also checks the transmit pulse over two full passes, which catches a wrong period, seed or marker state. It toggles the receive control away from 2'b10 and back, which catches a checker that keeps stale sync or reports a nonzero code before re-locking.

// File: rtl/char_bist_pkg.sv
package char_bist_pkg;
  parameter int LFSR_W = 9;
  parameter int TAP    = 4;
  localparam int CHAR_W = LFSR_W + 1;

  localparam logic [LFSR_W-1:0] SEED = LFSR_W'(1);
  // state that steps into SEED: it marks the last character of a pass
  localparam logic [LFSR_W-1:0] LAST = {SEED[0] ^ SEED[TAP+1], SEED[LFSR_W-1:1]};

  localparam logic [1:0] RX_BIST_SEL = 2'b10;
  localparam logic [1:0] CODE_WAIT   = 2'b00;
  localparam logic [1:0] CODE_MATCH  = 2'b01;
  localparam logic [1:0] CODE_MISS   = 2'b10;

  typedef enum logic {ST_WAIT, ST_SYNC} chkState_t;

  typedef struct packed {
    logic       loadExp;   // reseed expectation from received character
    logic       advExp;    // free-run expectation by one step
    logic       bistOut;   // present status instead of data
    logic [1:0] code;
    logic       passMark;
  } chkStrobe_t;

  function automatic logic [LFSR_W-1:0] lfsrStep(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[TAP]};
  endfunction

  function automatic logic [CHAR_W-1:0] charOf(input logic [LFSR_W-1:0] s);
    return {^s, s};
  endfunction
endpackage

// File: rtl/bist_datapath.sv
module bist_datapath
  import char_bist_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              txBistEnN,
  input  logic [CHAR_W-1:0] txDataIn,
  output logic [CHAR_W-1:0] txDataOut,
  output logic              txErr,
  input  logic [CHAR_W-1:0] rxDataIn,
  output logic [CHAR_W-1:0] rxDataOut,
  output logic              rxStatus,
  input  chkStrobe_t        strobe,
  output logic              rxMatch,
  output logic              expIsLast
);
  logic [LFSR_W-1:0] txState;
  logic [LFSR_W-1:0] expState;

  // transmit generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          txState <= SEED;
    else if (txBistEnN) txState <= SEED;
    else                txState <= lfsrStep(txState);
  end

  assign txDataOut = txBistEnN ? txDataIn : charOf(txState);
  assign txErr     = !txBistEnN && (txState == LAST);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    txErr |=> !txErr);
  a_r2_state_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    txState != '0);

  // receive expectation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               expState <= '0;
    else if (strobe.loadExp) expState <= lfsrStep(rxDataIn[LFSR_W-1:0]);
    else if (strobe.advExp)  expState <= lfsrStep(expState);
  end

  assign rxMatch   = (rxDataIn == charOf(expState));
  assign expIsLast = (expState == LAST);

  // receive output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxDataOut <= '0;
      rxStatus  <= 1'b0;
    end else begin
      rxDataOut <= strobe.bistOut ? {{(CHAR_W-2){1'b0}}, strobe.code} : rxDataIn;
      rxStatus  <= strobe.passMark;
    end
  end

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bistOut |=> rxDataOut[CHAR_W-1:2] == '0);
  a_r9_status_code: assert property (@(posedge clk) disable iff (!rstN)
    rxStatus |-> rxDataOut[1:0] != CODE_WAIT);
endmodule

// File: rtl/bist_control.sv
module bist_control
  import char_bist_pkg::*;
#(
  parameter int SYNC_MATCHES = 3,
  parameter int LOSS_ERRORS  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] rxBistCtl,
  input  logic       rxMatch,
  input  logic       expIsLast,
  output chkStrobe_t strobe
);
  localparam int MW = $clog2(SYNC_MATCHES + 1);
  localparam int EW = $clog2(LOSS_ERRORS + 1);

  chkState_t     curState, nxtState;
  logic [MW-1:0] matchCnt, matchNxt;
  logic [EW-1:0] errCnt, errNxt;
  logic          active;

  assign active = (rxBistCtl == RX_BIST_SEL);

  always_comb begin
    nxtState        = curState;
    matchNxt        = matchCnt;
    errNxt          = errCnt;
    strobe          = '0;
    strobe.bistOut  = active;
    if (!active) begin
      nxtState       = ST_WAIT;
      matchNxt       = '0;
      errNxt         = '0;
      strobe.loadExp = 1'b1;
    end else if (curState == ST_WAIT) begin
      strobe.loadExp = 1'b1;
      strobe.code    = CODE_WAIT;
      if (rxMatch) begin
        if (matchCnt == MW'(SYNC_MATCHES - 1)) begin
          nxtState = ST_SYNC;
          matchNxt = '0;
          errNxt   = '0;
        end else begin
          matchNxt = matchCnt + MW'(1);
        end
      end else begin
        matchNxt = '0;
      end
    end else begin
      strobe.code     = rxMatch ? CODE_MATCH : CODE_MISS;
      strobe.passMark = expIsLast;
      if (!rxMatch && errCnt == EW'(LOSS_ERRORS - 1)) begin
        nxtState       = ST_WAIT;
        matchNxt       = '0;
        errNxt         = '0;
        strobe.loadExp = 1'b1;
      end else begin
        strobe.advExp = 1'b1;
        errNxt        = expIsLast ? '0 : errCnt + EW'(!rxMatch);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= ST_WAIT;
      matchCnt <= '0;
      errCnt   <= '0;
    end else begin
      curState <= nxtState;
      matchCnt <= matchNxt;
      errCnt   <= errNxt;
    end
  end

  a_r8_errcnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    errCnt < EW'(LOSS_ERRORS));
  a_r6_no_sync_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_WAIT && !rxMatch) |=> curState == ST_WAIT);
  a_r4_idle_wait: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> curState == ST_WAIT);
endmodule

// File: rtl/char_bist_link.sv
module char_bist_link
  import char_bist_pkg::*;
#(
  parameter int SYNC_MATCHES = 3,
  parameter int LOSS_ERRORS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txBistEnN,
  input  logic [CHAR_W-1:0] txDataIn,
  output logic [CHAR_W-1:0] txDataOut,
  output logic              txErr,
  input  logic [1:0]        rxBistCtl,
  input  logic [CHAR_W-1:0] rxDataIn,
  output logic [CHAR_W-1:0] rxDataOut,
  output logic              rxStatus
);
  chkStrobe_t strobe;
  logic       rxMatch;
  logic       expIsLast;

  bist_datapath u_path (
    .clk(clk), .rstN(rstN),
    .txBistEnN(txBistEnN), .txDataIn(txDataIn),
    .txDataOut(txDataOut), .txErr(txErr),
    .rxDataIn(rxDataIn), .rxDataOut(rxDataOut), .rxStatus(rxStatus),
    .strobe(strobe), .rxMatch(rxMatch), .expIsLast(expIsLast)
  );

  bist_control #(.SYNC_MATCHES(SYNC_MATCHES), .LOSS_ERRORS(LOSS_ERRORS)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxBistCtl(rxBistCtl),
    .rxMatch(rxMatch), .expIsLast(expIsLast), .strobe(strobe)
  );
endmodule

// File: tb/char_bist_link_tb.sv
`timescale 1ns/1ps
module char_bist_link_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txBistEnN = 1'b1;
  logic [9:0] txDataIn = '0;
  logic [9:0] txDataOut;
  logic       txErr;
  logic [1:0] rxBistCtl = 2'b00;
  logic [9:0] rxDataIn;
  logic [9:0] rxDataOut;
  logic       rxStatus;
  logic       useLoop = 1'b0;
  logic [9:0] errMask = '0;
  logic [9:0] rxDrive = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign rxDataIn = useLoop ? (txDataOut ^ errMask) : rxDrive;

  char_bist_link u_dut (
    .clk(clk), .rstN(rstN), .txBistEnN(txBistEnN), .txDataIn(txDataIn),
    .txDataOut(txDataOut), .txErr(txErr), .rxBistCtl(rxBistCtl),
    .rxDataIn(rxDataIn), .rxDataOut(rxDataOut), .rxStatus(rxStatus)
  );

  // independent reference of the sequence as stated in R2
  function automatic logic [8:0] nxt9(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction
  function automatic logic [9:0] chr9(input logic [8:0] s);
    return {^s, s};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [9:0] qData[$];
  logic       qStat[$];
  string      qTag[$];

  // bench models
  logic [8:0] bTx = 9'h001;
  int         txIdx = 0;
  int         pulseCnt = 0;
  bit         mSync = 0;
  int         mCnt = 0, mErr = 0;
  logic [8:0] mExp = '0;
  bit         justLost = 0;

  task automatic step(input logic enN, input logic [1:0] ctl, input logic [9:0] mask,
                      input logic loop, input logic [9:0] rxD, input logic [9:0] txD);
    logic [9:0] c, ed;
    logic       es;
    bit         m;
    string      tg;
    @(negedge clk);
    txBistEnN = enN; rxBistCtl = ctl; errMask = mask; useLoop = loop;
    rxDrive = rxD; txDataIn = txD;
    #1;
    if (enN == 1'b0) begin
      chk(txDataOut == chr9(bTx), "R2 sequence", {1'b0, txDataOut}, {1'b0, chr9(bTx)});
      chk(txErr == ((txIdx % 511) == 510), "R3 pass pulse", {10'b0, txErr}, {10'b0, ((txIdx % 511) == 510)});
      if (txErr) pulseCnt++;
      bTx = nxt9(bTx); txIdx++;
    end else begin
      chk(txDataOut == txD, "R1 passthrough", {1'b0, txDataOut}, {1'b0, txD});
      chk(txErr == 1'b0, "R1 err low", {10'b0, txErr}, 11'b0);
      bTx = 9'h001; txIdx = 0;
    end
    c = rxDataIn;
    if (ctl != 2'b10) begin
      ed = c; es = 0; tg = "R4 rx passthrough";
      mSync = 0; mCnt = 0; mErr = 0; mExp = nxt9(c[8:0]);
    end else if (!mSync) begin
      ed = 10'b0; es = 0; tg = justLost ? "R8 back to wait" : "R6 waiting code";
      justLost = 0;
      m = (c == chr9(mExp));
      if (m) begin
        if (mCnt == 2) begin mSync = 1; mCnt = 0; mErr = 0; end
        else mCnt++;
      end else mCnt = 0;
      mExp = nxt9(c[8:0]);
    end else begin
      m = (c == chr9(mExp));
      ed = m ? 10'b01 : 10'b10;
      es = (mExp == 9'h100);
      tg = es ? "R9 pass marker" : (m ? "R7 match" : "R7 mismatch");
      if (!m && mErr == 3) begin
        mSync = 0; mCnt = 0; mErr = 0; mExp = nxt9(c[8:0]); justLost = 1;
      end else begin
        mErr = (mExp == 9'h100) ? 0 : mErr + (m ? 0 : 1);
        mExp = nxt9(mExp);
      end
    end
    qData.push_back(ed); qStat.push_back(es); qTag.push_back(tg);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (qData.size() > 0) begin
        logic [9:0] ed; logic es; string tg;
        ed = qData.pop_front(); es = qStat.pop_front(); tg = qTag.pop_front();
        chk(rxDataOut == ed, tg, {1'b0, rxDataOut}, {1'b0, ed});
        chk(rxStatus == es, {tg, " R5/R9 status"}, {10'b0, rxStatus}, {10'b0, es});
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  function automatic logic [9:0] pickMask(input int i);
    int p, ps;
    p = i % 511; ps = i / 511;
    if (ps == 1 && (p == 100 || p == 200 || p == 210)) return 10'h004;
    if (ps == 2 && (p == 495 || p == 500 || p == 505)) return 10'h004;
    if (ps == 3 && (p == 5 || p == 10 || p == 15)) return 10'h004;
    if (ps == 4 && (p == 50 || p == 60 || p == 70 || p == 80)) return 10'h004;
    return 10'h000;
  endfunction

  initial begin
    rxDrive = 10'h2A5; txDataIn = 10'h15A;
    #20;
    chk(rxDataOut == 10'h000, "R10 reset data", {1'b0, rxDataOut}, 11'h0);
    chk(rxStatus == 1'b0, "R10 reset status", {10'b0, rxStatus}, 11'h0);
    chk(txErr == 1'b0, "R10 reset txErr", {10'b0, txErr}, 11'h0);
    @(negedge clk); rstN = 1'b1;

    // R1/R4: passthrough with assorted control codes and data
    for (int i = 0; i < 12; i++)
      step(1'b1, 2'(i % 4 == 2 ? 3 : i % 4), 10'h0, 1'b0, 10'(i * 77 + 5), 10'(i * 131 + 9));

    // R2/R3: two full passes of the generator, looped to passthrough rx
    pulseCnt = 0;
    for (int i = 0; i < 1030; i++)
      step(1'b0, 2'b00, 10'h0, 1'b1, 10'h0, 10'h0);
    chk(pulseCnt == 2, "R3 pulse count", 11'(pulseCnt), 11'd2);

    // restart generator, then checker with error bursts (R6-R9)
    step(1'b1, 2'b00, 10'h0, 1'b1, 10'h0, 10'h3FF);
    for (int i = 0; i < 5 * 511 + 20; i++)
      step(1'b0, 2'b10, pickMask(i), 1'b1, 10'h0, 10'h0);

    // R4: leave checker mode, then re-lock (R6)
    for (int i = 0; i < 10; i++)
      step(1'b0, 2'b11, 10'h0, 1'b1, 10'h0, 10'h0);
    for (int i = 0; i < 30; i++)
      step(1'b0, 2'b10, 10'h0, 1'b1, 10'h0, 10'h0);

    // R1 after a BIST run
    for (int i = 0; i < 4; i++)
      step(1'b1, 2'b01, 10'h0, 1'b0, 10'(i * 211), 10'(i * 97 + 1));

    @(posedge clk); #2;
    @(posedge clk); #2;
    finishRun();
  end
endmodule